// File: doc/BRIEF.md
# Stream-to-Ethernet Frame Packer

This block drains 32-bit words from a FIFO-style source and turns them into raw Ethernet frames on a byte-wide transmit stream. The frames go to a MAC that appends the frame check sequence itself. Every frame starts with a 14-byte header: destination address, source address and a private EtherType reserved for local experiments. A 16-bit length field and the payload words follow, each word sent most significant byte first. No handshake or acknowledgement exists between the two ends: a frame leaves as soon as the block decides to close it.

The length field follows a split rule. A frame with too little data to reach the minimum Ethernet payload carries its real data byte count in the length field and is padded with zero bytes up to the minimum size. A frame that reaches the minimum carries zero in the length field, so the receiver knows no padding is present. Frames are closed in two cases. One is when they reach the maximum payload, and the rest of the stream then continues in a new frame. The other is when the source has been empty for a programmable number of cycles.

The first eleven words of a frame are held in a small buffer before the header goes out, because the length field comes before the data it describes. After that, words pass straight through. The decision to end the frame is taken at the last byte of each word.

Top module: `stream_frame_packer`

## Requirements
- R1: Bytes 1 to 6 of every frame are the destination address 02:11:22:33:44:55, bytes 7 to 12 are the source address 02:AA:BB:CC:DD:EE, and bytes 13 and 14 are the type code 0x88B5. Each field is sent most significant byte first.
- R2: A frame holding n >= 11 words has 0x0000 in its length bytes (15 and 16) and is exactly 16 + 4n bytes long, with no padding.
- R3: A frame holding n words, 1 <= n <= 10, has 4n in its length bytes, sent high byte first. The data is followed by zero bytes up to a total of 60 bytes, and tx_last is on byte 60.
- R4: Each word is sent as bits 31:24 first, then 23:16, 15:8 and 7:0, starting at byte 17. Words appear in the order they were accepted.
- R5: A frame carries at most 374 words (1512 bytes). The 375th word starts a new frame with a fresh header.
- R6: After the last word of a frame with fewer than 11 words is accepted, that frame starts between L and L+3 cycles later, where L is cfg_idle_limit. No frame is sent while no word has been accepted.
- R7: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold their values. No byte is dropped or repeated.
- R8: Words that arrive with gaps shorter than the idle limit join the current frame, with no header inserted among them.
- R9: After reset, tx_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_idle_limit | input | 16 | Idle cycles with an empty source before a frame is closed |
| in_data | input | 32 | Word from the source FIFO |
| in_valid | input | 1 | Source FIFO has a word |
| in_ready | output | 1 | Word is taken on this cycle when in_valid is high |
| tx_data | output | 8 | Frame byte toward the MAC |
| tx_valid | output | 1 | tx_data holds a frame byte |
| tx_last | output | 1 | Marks the final byte of a frame |
| tx_ready | input | 1 | MAC accepts the byte this cycle |

## Verification
The hold assertion for R7 relies on the source behaving like a FIFO output: once in_valid rises, it stays high with the same word until in_ready takes it. This matters because at a word boundary tx_valid follows in_valid. The driver tasks keep that promise: each word is raised one cycle after a clock edge and held until it is accepted. cfg_idle_limit is changed only while no frame is being built. Backpressure comes from a shift register pattern on tx_ready, and the monitor checks byte stability on every stalled cycle.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
    localparam int HDR_BYTES = 14;   // destination, source, type
    localparam int LEN_BYTES = 2;    // length field after the type
    typedef enum logic {
        ST_COLLECT = 1'b0,
        ST_SEND    = 1'b1
    } state_e;
endpackage

// File: rtl/sfp_idle_timer.sv
module sfp_idle_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick && (cnt_q != '1)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q >= limit);

    // R6: the idle count only grows or saturates unless cleared
    a_r6_timer_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/sfp_word_buf.sv
module sfp_word_buf #(
    parameter int DEPTH = 11,
    parameter int W     = 32,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(i))) mem_q[i] <= wdata;
        end
    end

    assign rdata = (int'(raddr) < DEPTH) ? mem_q[raddr] : '0;

    // R4: words are only stored inside the buffer range
    a_r4_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> int'(waddr) < DEPTH);
endmodule

// File: rtl/sfp_byte_sel.sv
module sfp_byte_sel #(
    parameter int          WORD_BYTES = 4,
    parameter int          POS_W      = 11,
    parameter int          CNT_W      = 4,
    parameter int          BSEL_W     = 2,
    parameter logic [47:0] DST_MAC    = 48'h02_11_22_33_44_55,
    parameter logic [47:0] SRC_MAC    = 48'h02_AA_BB_CC_DD_EE,
    parameter logic [15:0] ETHER_TYPE = 16'h88B5
) (
    input  logic [POS_W-1:0]        pos,
    input  logic [POS_W-1:0]        widx,
    input  logic [BSEL_W-1:0]       bsel,
    input  logic                    long_f,
    input  logic [CNT_W-1:0]        cnt,
    input  logic [8*WORD_BYTES-1:0] word,
    output logic [7:0]              byte_o
);
    localparam int WORD_W = 8 * WORD_BYTES;

    logic [15:0]       len16;
    logic [WORD_W-1:0] shifted;
    int                p;

    always_comb begin
        p       = int'(pos);
        len16   = long_f ? 16'd0 : 16'(int'(cnt) * WORD_BYTES);
        shifted = word << (8 * int'(bsel));
        if (p < 6) begin
            byte_o = DST_MAC[8*(5-p) +: 8];
        end else if (p < 12) begin
            byte_o = SRC_MAC[8*(11-p) +: 8];
        end else if (p == 12) begin
            byte_o = ETHER_TYPE[15:8];
        end else if (p == 13) begin
            byte_o = ETHER_TYPE[7:0];
        end else if (p == 14) begin
            byte_o = len16[15:8];
        end else if (p == 15) begin
            byte_o = len16[7:0];
        end else if (long_f || (widx < POS_W'(cnt))) begin
            byte_o = shifted[WORD_W-1 -: 8];
        end else begin
            byte_o = 8'h00;
        end
    end
endmodule

// File: rtl/stream_frame_packer.sv
module stream_frame_packer
    import sfp_pkg::*;
#(
    parameter int          WORD_BYTES  = 4,
    parameter int          MIN_PAYLOAD = 46,
    parameter int          MAX_PAYLOAD = 1500,
    parameter int          IDLE_W      = 16,
    parameter logic [47:0] DST_MAC     = 48'h02_11_22_33_44_55,
    parameter logic [47:0] SRC_MAC     = 48'h02_AA_BB_CC_DD_EE,
    parameter logic [15:0] ETHER_TYPE  = 16'h88B5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDLE_W-1:0]       cfg_idle_limit,
    input  logic [8*WORD_BYTES-1:0] in_data,
    input  logic                    in_valid,
    output logic                    in_ready,
    output logic [7:0]              tx_data,
    output logic                    tx_valid,
    output logic                    tx_last,
    input  logic                    tx_ready
);
    localparam int WORD_W     = 8 * WORD_BYTES;
    localparam int MIN_WORDS  = (MIN_PAYLOAD - LEN_BYTES) / WORD_BYTES;
    localparam int MAX_WORDS  = (MAX_PAYLOAD - LEN_BYTES) / WORD_BYTES;
    localparam int DATA_START = HDR_BYTES + LEN_BYTES;
    localparam int SHORT_END  = HDR_BYTES + MIN_PAYLOAD - 1;
    localparam int LONG_LIMIT = DATA_START + MAX_WORDS * WORD_BYTES;
    localparam int POS_W      = $clog2(LONG_LIMIT + 1);
    localparam int CNT_W      = $clog2(MIN_WORDS + 1);
    localparam int ADDR_W     = $clog2(MIN_WORDS);
    localparam int BSEL_W     = $clog2(WORD_BYTES);

    typedef struct packed {
        state_e             state;
        logic [CNT_W-1:0]   cnt;    // words held in the buffer
        logic [POS_W-1:0]   pos;    // byte index in the frame
        logic               close;  // end decided at a word boundary
        logic [WORD_W-1:0]  cur;    // word beyond the buffer
    } regs_t;

    regs_t r_d, r_q;

    logic [POS_W-1:0]  doff, widx;
    logic [BSEL_W-1:0] bsel;
    logic              at_data, in_buf, long_f, wait_pt, end_frame;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] buf_rdata, word;
    logic              wr_en, tmr_clr, tmr_tick, expired;
    logic [7:0]        sel_byte;

    // frame position decode
    always_comb begin
        doff    = r_q.pos - POS_W'(DATA_START);
        widx    = doff >> BSEL_W;
        bsel    = doff[BSEL_W-1:0];
        at_data = (r_q.pos >= POS_W'(DATA_START));
        in_buf  = (widx < POS_W'(MIN_WORDS));
        rd_addr = in_buf ? widx[ADDR_W-1:0] : '0;
        word    = in_buf ? buf_rdata : r_q.cur;
        long_f  = (r_q.cnt == CNT_W'(MIN_WORDS));
        wait_pt = long_f && at_data && (bsel == BSEL_W'(WORD_BYTES - 1))
                  && (widx >= POS_W'(MIN_WORDS - 1))
                  && (widx <  POS_W'(MAX_WORDS - 1));
        end_frame = long_f
                  ? (at_data && (bsel == BSEL_W'(WORD_BYTES - 1))
                     && (widx == POS_W'(MAX_WORDS - 1)))
                  : (r_q.pos == POS_W'(SHORT_END));
    end

    // next-state computation
    always_comb begin
        r_d      = r_q;
        in_ready = 1'b0;
        tx_valid = 1'b0;
        tx_last  = 1'b0;
        wr_en    = 1'b0;
        tmr_clr  = 1'b0;
        tmr_tick = 1'b0;
        unique case (r_q.state)
            ST_COLLECT: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    wr_en   = 1'b1;
                    tmr_clr = 1'b1;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_W'(MIN_WORDS - 1)) begin
                        r_d.state = ST_SEND;
                        r_d.pos   = '0;
                    end
                end else if (r_q.cnt != '0) begin
                    if (expired) begin
                        r_d.state = ST_SEND;
                        r_d.pos   = '0;
                        tmr_clr   = 1'b1;
                    end else begin
                        tmr_tick = 1'b1;
                    end
                end else begin
                    tmr_clr = 1'b1;
                end
            end
            ST_SEND: begin
                if (wait_pt && !r_q.close) begin
                    if (in_valid) begin
                        tx_valid = 1'b1;
                        in_ready = tx_ready;
                        tmr_clr  = 1'b1;
                        if (tx_ready) begin
                            r_d.cur = in_data;
                            r_d.pos = r_q.pos + 1'b1;
                        end
                    end else if (expired) begin
                        r_d.close = 1'b1;
                    end else begin
                        tmr_tick = 1'b1;
                    end
                end else begin
                    tx_valid = 1'b1;
                    tx_last  = r_q.close || end_frame;
                    tmr_clr  = 1'b1;
                    if (tx_ready) begin
                        r_d.pos = r_q.pos + 1'b1;
                        if (tx_last) begin
                            r_d.state = ST_COLLECT;
                            r_d.cnt   = '0;
                            r_d.pos   = '0;
                            r_d.close = 1'b0;
                        end
                    end
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{state: ST_COLLECT, default: '0};
        else        r_q <= r_d;
    end

    sfp_word_buf #(
        .DEPTH (MIN_WORDS),
        .W     (WORD_W),
        .AW    (ADDR_W)
    ) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (r_q.cnt[ADDR_W-1:0]),
        .wdata (in_data),
        .raddr (rd_addr),
        .rdata (buf_rdata)
    );

    sfp_idle_timer #(
        .W (IDLE_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .tick    (tmr_tick),
        .limit   (cfg_idle_limit),
        .expired (expired)
    );

    sfp_byte_sel #(
        .WORD_BYTES (WORD_BYTES),
        .POS_W      (POS_W),
        .CNT_W      (CNT_W),
        .BSEL_W     (BSEL_W),
        .DST_MAC    (DST_MAC),
        .SRC_MAC    (SRC_MAC),
        .ETHER_TYPE (ETHER_TYPE)
    ) u_sel (
        .pos    (r_q.pos),
        .widx   (widx),
        .bsel   (bsel),
        .long_f (long_f),
        .cnt    (r_q.cnt),
        .word   (word),
        .byte_o (sel_byte)
    );

    assign tx_data = sel_byte;

    // R7: a stalled byte stays put (source holds in_valid until taken)
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    // R3: no frame ends before the minimum size
    a_r3_min_frame: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_last |-> r_q.pos >= POS_W'(SHORT_END));

    // R5: the byte index never runs past a full frame
    a_r5_max_frame: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.state == ST_SEND |-> r_q.pos < POS_W'(LONG_LIMIT));

    // R6: sending only starts with at least one word held
    a_r6_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.state == ST_SEND |-> r_q.cnt != '0);

    // R8: no word is taken while the header is going out
    a_r8_no_accept_in_header: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && r_q.state == ST_SEND |-> r_q.pos >= POS_W'(DATA_START));
endmodule

// File: tb/tb_stream_frame_packer.sv
module tb_stream_frame_packer;
    localparam logic [47:0] DST = 48'h02_11_22_33_44_55;
    localparam logic [47:0] SRC = 48'h02_AA_BB_CC_DD_EE;
    localparam logic [15:0] ETYPE = 16'h88B5;
    localparam int MAXB = 1536;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_idle_limit = 16'd8;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_last;
    logic        tx_ready = 1'b1;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    stream_frame_packer dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_idle_limit (cfg_idle_limit),
        .in_data        (in_data),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .tx_data        (tx_data),
        .tx_valid       (tx_valid),
        .tx_last        (tx_last),
        .tx_ready       (tx_ready)
    );

    always #2.5 clk = ~clk;

    task automatic fail(input string req, input string what, input int act, input int exp);
        fails++;
        $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fail("watchdog", "cycle limit", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // backpressure pattern
    logic       bp_on = 1'b0;
    logic [7:0] lfsr = 8'hA7;
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_ready = bp_on ? (lfsr[0] | lfsr[2]) : 1'b1;
    end

    // output monitor
    logic [7:0] cur_b [MAXB];
    logic [7:0] lf    [MAXB];
    int   cur_len = 0;
    int   lf_len = 0;
    int   frames_done = 0;
    int   valid_seen = 0;
    logic hold_pend = 1'b0;
    logic [7:0] hold_d;
    logic hold_l;

    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend) begin
                checks++;
                if (!(tx_valid && tx_data == hold_d && tx_last == hold_l))
                    fail("R7", "stalled byte changed", int'({tx_valid, tx_last, tx_data}),
                         int'({1'b1, hold_l, hold_d}));
            end
            hold_pend = tx_valid && !tx_ready;
            hold_d = tx_data;
            hold_l = tx_last;
            if (tx_valid) valid_seen++;
            if (tx_valid && tx_ready) begin
                if (cur_len < MAXB) cur_b[cur_len] = tx_data;
                cur_len++;
                if (tx_last) begin
                    for (int k = 0; k < MAXB; k++) lf[k] = cur_b[k];
                    lf_len = cur_len;
                    cur_len = 0;
                    frames_done++;
                end
            end
        end
    end

    function automatic logic [31:0] wv(input int seed, input int i);
        return (32'(seed) * 32'h0001_0001) ^ (32'(i) * 32'h0103_0507 + 32'h1122_3344);
    endfunction

    function automatic logic [7:0] hdr_exp(input int p);
        if (p < 6)  return DST[8*(5-p) +: 8];
        if (p < 12) return SRC[8*(11-p) +: 8];
        if (p == 12) return ETYPE[15:8];
        return ETYPE[7:0];
    endfunction

    task automatic sync();
        @(posedge clk);
        #1;
    endtask

    task automatic push_word(input logic [31:0] w);
        in_data  = w;
        in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic push_seq(input int n, input int seed, input int first);
        for (int i = 0; i < n; i++) push_word(wv(seed, first + i));
    endtask

    task automatic idle(input int n);
        repeat (n) sync();
    endtask

    task automatic wait_frames(input int target, input string req);
        int n = 0;
        while (frames_done < target && n < 8000) begin
            @(negedge clk);
            n++;
        end
        checks++;
        if (frames_done < target) fail(req, "frame never completed", frames_done, target);
    endtask

    task automatic check_frame(input string req, input int nw, input int seed, input int first);
        int exp_len;
        int lenv;
        int bad;
        exp_len = (nw >= 11) ? 16 + 4 * nw : 60;
        lenv    = (nw >= 11) ? 0 : 4 * nw;
        checks++;
        if (lf_len != exp_len) fail(req, "frame length", lf_len, exp_len);
        // R1 header
        checks++;
        bad = -1;
        for (int p = 0; p < 14; p++) if (bad < 0 && lf[p] != hdr_exp(p)) bad = p;
        if (bad >= 0) fail("R1", "header byte", int'(lf[bad]), int'(hdr_exp(bad)));
        // R2 / R3 length field
        checks++;
        if ({lf[14], lf[15]} != 16'(lenv))
            fail((nw >= 11) ? "R2" : "R3", "length field", int'({lf[14], lf[15]}), lenv);
        // R4 payload order
        checks++;
        bad = -1;
        for (int k = 0; k < 4 * nw; k++) begin
            logic [31:0] w;
            w = wv(seed, first + k / 4);
            if (bad < 0 && 16 + k < MAXB && lf[16 + k] != w[8*(3 - k % 4) +: 8]) bad = k;
        end
        if (bad >= 0) begin
            logic [31:0] w2;
            w2 = wv(seed, first + bad / 4);
            fail("R4", "payload byte", int'(lf[16 + bad]), int'(w2[8*(3 - bad % 4) +: 8]));
        end
        // R3 padding
        if (nw < 11) begin
            checks++;
            bad = -1;
            for (int k = 16 + 4 * nw; k < 60; k++) if (bad < 0 && lf[k] != 8'h00) bad = k;
            if (bad >= 0) fail("R3", "pad byte", int'(lf[bad]), 0);
        end
    endtask

    // R9
    task automatic t_reset();
        @(negedge clk);
        checks++;
        if (tx_valid !== 1'b0) fail("R9", "tx_valid after reset", int'(tx_valid), 0);
        checks++;
        if (in_ready !== 1'b1) fail("R9", "in_ready after reset", int'(in_ready), 1);
    endtask

    // R3 R6: short frame and its start time after the idle limit
    task automatic t_short_timing();
        int f0;
        int n;
        f0 = frames_done;
        cfg_idle_limit = 16'd8;
        sync();
        push_seq(3, 1, 0);
        n = 0;
        while (!tx_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        checks++;
        if (n < 8 || n > 11) fail("R6", "cycles to frame start", n, 10);
        wait_frames(f0 + 1, "R6");
        check_frame("R3", 3, 1, 0);
    endtask

    task automatic t_short(input int nw, input int seed, input string req);
        int f0;
        f0 = frames_done;
        sync();
        push_seq(nw, seed, 0);
        wait_frames(f0 + 1, req);
        check_frame(req, nw, seed, 0);
    endtask

    // R7: backpressure over a long frame
    task automatic t_backpressure();
        int f0;
        f0 = frames_done;
        bp_on = 1'b1;
        sync();
        push_seq(20, 7, 0);
        wait_frames(f0 + 1, "R7");
        check_frame("R7", 20, 7, 0);
        f0 = frames_done;
        sync();
        push_seq(5, 8, 0);
        wait_frames(f0 + 1, "R7");
        check_frame("R7", 5, 8, 0);
        bp_on = 1'b0;
    endtask

    // R5: split at 374 words
    task automatic t_split();
        int f0;
        f0 = frames_done;
        sync();
        fork
            push_seq(380, 9, 0);
            begin
                wait_frames(f0 + 1, "R5");
                check_frame("R5", 374, 9, 0);
                wait_frames(f0 + 2, "R5");
                check_frame("R5", 6, 9, 374);
            end
        join
    endtask

    // R8: gaps shorter than the limit keep one frame
    task automatic t_gaps();
        int f0;
        cfg_idle_limit = 16'd20;
        f0 = frames_done;
        sync();
        push_seq(3, 11, 0);
        idle(4);
        push_seq(2, 11, 3);
        wait_frames(f0 + 1, "R8");
        checks++;
        if (frames_done != f0 + 1) fail("R8", "frames for short gap", frames_done - f0, 1);
        check_frame("R8", 5, 11, 0);
        f0 = frames_done;
        sync();
        push_seq(15, 12, 0);
        idle(6);
        push_seq(5, 12, 15);
        wait_frames(f0 + 1, "R8");
        check_frame("R8", 20, 12, 0);
        idle(40);
        checks++;
        if (frames_done != f0 + 1) fail("R8", "frames for long gap", frames_done - f0, 1);
        cfg_idle_limit = 16'd8;
    endtask

    // R6: no words, no frame
    task automatic t_no_data();
        int f0;
        int v0;
        f0 = frames_done;
        v0 = valid_seen;
        idle(100);
        checks++;
        if (frames_done != f0) fail("R6", "frames while empty", frames_done - f0, 0);
        checks++;
        if (valid_seen != v0) fail("R6", "tx_valid while empty", valid_seen - v0, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_no_data();
        t_short_timing();
        t_short(1, 2, "R3");
        t_short(10, 3, "R3");
        t_short(11, 4, "R2");
        t_short(17, 5, "R2");
        t_backpressure();
        t_gaps();
        t_split();
        t_no_data();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule